// File: doc/BRIEF.md
# Write Completion Status Readback

This block owns the read data path of a byte-alterable nonvolatile memory while an internal programming cycle may be running. A page write controller supplies a busy flag and the most significant bit of the byte it stored last; the storage array supplies the addressed read word. On every read, when chip select and output enable are both low, the block returns either the array word or a status word. A polling host learns that programming is done by one of two methods. In the first, it compares bit 7 with the bit it wrote. In the second, it watches whether bit 6 still changes between reads.

While busy, bit 7 of the read word is the inverse of the last written bit 7. Bit 6 flips once for each separate read, and the low six bits read as zero. When busy drops, reads return true array data and the flip state freezes. A new programming cycle clears the flip state. Outputs are registered, so the read word and the bus drive enable follow the sampled strobe by one clock.

Top module: `wr_status_readback`

## Requirements
- R1: `bus_drive` is high in the cycle after a clock edge that samples `csel_n` and `oe_n` both low, and low after any edge that samples either one high.
- R2: After an edge that samples `prog_busy` high, `rd_data[7]` equals the inverse of `last_wr_msb` sampled at that edge.
- R3: While busy, a read start flips `rd_data[6]` relative to the previous cycle's value. A read start is an edge where the strobe is sampled low-active after being inactive at the previous edge. This holds when the previous edge was also busy.
- R4: While busy, a strobe held active over several edges leaves `rd_data[6]` unchanged after the first edge.
- R5: After an edge that samples `prog_busy` high, `rd_data[5:0]` are zero.
- R6: After an edge that samples `prog_busy` low, `rd_data` equals `arr_rdata` sampled at that edge.
- R7: At an edge where `prog_busy` is sampled high after being low (a new programming cycle), the toggle state is cleared, so `rd_data[6]` is 0. This takes priority over a read start at the same edge.
- R8: After an edge with `rst_n` low, `bus_drive` is 0, `rd_data` is 0 and the toggle state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csel_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_busy | input | 1 | Internal programming cycle in progress |
| last_wr_msb | input | 1 | Bit 7 of the last byte written |
| arr_rdata | input | 8 | Array read word |
| rd_data | output | 8 | Registered read word |
| bus_drive | output | 1 | Enable for the tri-state data bus |

## Verification
Two events can fall on the same clock edge: the start of a new programming cycle, which clears the toggle state, and the start of a read, which flips it. The bench forces this by raising the busy flag and starting a read at the same edge. It expects the cleared value (0) on bit 6, then expects 1 on the next separate read. Random runs also make busy start and end next to read starts, and a reference model built from R3, R4 and R7 judges every cycle.

// File: rtl/wsr_pkg.sv
// Shared field positions for the status readback block.
// Assumes an 8-bit read word with two status bits at the top.
package wsr_pkg;
    localparam int WORD_W   = 8;
    localparam int POLL_POS = 7;   // inverted last-written bit
    localparam int TOG_POS  = 6;   // flips on each read while busy
    localparam int RSV_W    = 6;   // reserved low bits, read as zero
endpackage

// File: rtl/wsr_edge.sv
// Rising-edge detector on a sampled level.
// Assumes the level is already synchronous to clk.
module wsr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    // remember the level seen at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/wsr_toggle.sv
// Toggle state for the flipping status bit.
// Clear has priority over advance; tog_next is the value after this edge.
module wsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic tog_next
);
    logic tog_q;

    // next toggle value: clear wins, else flip on advance
    always_comb begin
        if (clear)        tog_next = 1'b0;
        else if (advance) tog_next = ~tog_q;
        else              tog_next = tog_q;
    end

    // hold the toggle state
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_next;
    end
endmodule

// File: rtl/wsr_mux.sv
// Selects the array word or the status word for the read path.
// Purely combinational; the caller registers the result.
module wsr_mux #(
    parameter int WORD_W   = wsr_pkg::WORD_W,
    parameter int POLL_POS = wsr_pkg::POLL_POS,
    parameter int TOG_POS  = wsr_pkg::TOG_POS
) (
    input  logic              busy,
    input  logic              last_msb,
    input  logic              tog,
    input  logic [WORD_W-1:0] arr,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] status;

    // build the status word bit by bit
    for (genvar i = 0; i < WORD_W; i++) begin : g_stat
        if (i == POLL_POS) begin : g_poll
            assign status[i] = ~last_msb;
        end else if (i == TOG_POS) begin : g_tog
            assign status[i] = tog;
        end else begin : g_rsv
            assign status[i] = 1'b0;
        end
    end

    // choose the source for this read
    always_comb begin
        word = busy ? status : arr;
    end
endmodule

// File: rtl/wr_status_readback.sv
// Read path with write completion status reporting.
// Assumes all inputs are synchronous to clk; outputs lag inputs by one edge.
module wr_status_readback #(
    parameter int WORD_W = wsr_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csel_n,
    input  logic              oe_n,
    input  logic              prog_busy,
    input  logic              last_wr_msb,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic [WORD_W-1:0] rd_data,
    output logic              bus_drive
);
    logic strobe, read_start, busy_start, tog_next;
    logic [WORD_W-1:0] word;

    assign strobe = ~csel_n & ~oe_n;

    wsr_edge u_rd_edge (
        .clk(clk), .rst_n(rst_n), .level(strobe), .rise(read_start)
    );

    wsr_edge u_busy_edge (
        .clk(clk), .rst_n(rst_n), .level(prog_busy), .rise(busy_start)
    );

    wsr_toggle u_tog (
        .clk(clk), .rst_n(rst_n),
        .clear(busy_start),
        .advance(prog_busy & read_start),
        .tog_next(tog_next)
    );

    wsr_mux #(.WORD_W(WORD_W)) u_mux (
        .busy(prog_busy), .last_msb(last_wr_msb), .tog(tog_next),
        .arr(arr_rdata), .word(word)
    );

    // register the read word and the bus drive enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            bus_drive <= 1'b0;
        end else begin
            rd_data   <= word;
            bus_drive <= strobe;
        end
    end
endmodule

// File: rtl/wsr_chk.sv
// Property checker for wr_status_readback, attached by bind.
module wsr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       csel_n,
    input logic       oe_n,
    input logic       prog_busy,
    input logic       last_wr_msb,
    input logic [7:0] arr_rdata,
    input logic [7:0] rd_data,
    input logic       bus_drive
);
    logic strobe;
    assign strobe = ~csel_n & ~oe_n;

    // R1
    drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> bus_drive == $past(strobe));
    // R2
    poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |=> rd_data[7] == ~$past(last_wr_msb));
    // R3
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && $past(prog_busy) && strobe && !$past(strobe))
        |=> rd_data[6] != $past(rd_data[6]));
    // R4
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && $past(prog_busy) && strobe && $past(strobe))
        |=> $stable(rd_data[6]));
    // R5
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |=> rd_data[5:0] == 6'd0);
    // R6
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_busy |=> rd_data == $past(arr_rdata));
    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && !$past(prog_busy)) |=> rd_data[6] == 1'b0);
endmodule

bind wr_status_readback wsr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .csel_n(csel_n), .oe_n(oe_n),
    .prog_busy(prog_busy), .last_wr_msb(last_wr_msb),
    .arr_rdata(arr_rdata), .rd_data(rd_data), .bus_drive(bus_drive)
);

// File: tb/sim_wr_status_readback.sv
module sim_wr_status_readback;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csel_n = 1'b1, oe_n = 1'b1, prog_busy = 1'b0, last_wr_msb = 1'b0;
    logic [7:0] arr_rdata = 8'h00;
    logic [7:0] rd_data;
    logic       bus_drive;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic m_tog = 1'b0, m_pstrobe = 1'b0, m_pbusy = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    wr_status_readback u0 (
        .clk(clk), .rst_n(rst_n), .csel_n(csel_n), .oe_n(oe_n),
        .prog_busy(prog_busy), .last_wr_msb(last_wr_msb),
        .arr_rdata(arr_rdata), .rd_data(rd_data), .bus_drive(bus_drive)
    );

    // expected toggle after an edge, from R3, R4, R7
    function automatic logic next_tog(logic tog, logic busy, logic pbusy,
                                      logic strobe, logic pstrobe);
        if (busy && !pbusy)             return 1'b0;
        if (busy && strobe && !pstrobe) return ~tog;
        return tog;
    endfunction

    // expected read word, from R2, R5, R6
    function automatic logic [7:0] exp_word(logic busy, logic msb, logic tog,
                                            logic [7:0] arr);
        if (busy) return {~msb, tog, 6'b0};
        return arr;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply one cycle of inputs, then check the registered outputs
    task automatic step(logic cs, logic oe, logic busy, logic msb, logic [7:0] arr);
        logic strobe;
        logic [7:0] w;
        @(negedge clk);
        csel_n = cs; oe_n = oe; prog_busy = busy; last_wr_msb = msb; arr_rdata = arr;
        strobe = !cs && !oe;
        m_tog = next_tog(m_tog, busy, m_pbusy, strobe, m_pstrobe);
        w = exp_word(busy, msb, m_tog, arr);
        m_pstrobe = strobe; m_pbusy = busy;
        @(posedge clk); #1;
        chk("R1", {7'd0, bus_drive}, {7'd0, strobe});
        if (busy) begin
            chk("R2", {7'd0, rd_data[7]}, {7'd0, w[7]});
            chk("R3 R4 R7", {7'd0, rd_data[6]}, {7'd0, w[6]});
            chk("R5", {2'd0, rd_data[5:0]}, {2'd0, w[5:0]});
        end else begin
            chk("R6", rd_data, w);
        end
    endtask

    // watchdog
    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic cs, oe, busy;
        void'($urandom(32'd2024));
        // R8: reset state
        csel_n = 1'b0; oe_n = 1'b0; prog_busy = 1'b1; arr_rdata = 8'h5A;
        repeat (2) @(posedge clk);
        #1;
        chk("R8", {7'd0, bus_drive}, 8'd0);
        chk("R8", rd_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1; csel_n = 1'b1; oe_n = 1'b1; prog_busy = 1'b0;
        m_tog = 1'b0; m_pstrobe = 1'b0; m_pbusy = 1'b0;

        // R6: idle reads return array data
        step(0, 0, 0, 0, 8'hA5);
        step(1, 1, 0, 0, 8'h3C);
        // R7: busy start and read start on the same edge, toggle cleared
        step(0, 0, 1, 0, 8'hFF);
        chk("R7", {7'd0, rd_data[6]}, 8'd0);
        // R4: long read does not toggle
        step(0, 0, 1, 0, 8'hFF);
        step(0, 0, 1, 0, 8'hFF);
        chk("R4", {7'd0, rd_data[6]}, 8'd0);
        // R3: separate reads flip bit 6
        step(1, 0, 1, 1, 8'h00);
        step(0, 0, 1, 1, 8'h00);
        chk("R3", {7'd0, rd_data[6]}, 8'd1);
        step(0, 1, 1, 1, 8'h00);
        step(0, 0, 1, 1, 8'h00);
        chk("R3", {7'd0, rd_data[6]}, 8'd0);
        // R6: completion gives true data
        step(0, 0, 0, 1, 8'h81);
        chk("R6", rd_data, 8'h81);

        // random phase
        busy = 1'b0;
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 11) == 0) busy = ~busy;
            cs = ($urandom_range(0, 3) == 0);
            oe = ($urandom_range(0, 2) == 0);
            step(cs, oe, busy, 1'($urandom_range(0, 1)), 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule